// File: doc/BRIEF.md
# Eager Transactional Conflict Detector with Abort Backoff and Serial-Mode Arbiter

This block sits on the snoop side of a small group of cores that run hardware transactions. A conflict is detected at access time, not at commit. When another core broadcasts an invalidate on the bus, each core's cache reports whether the snooped line belongs to that core's transactional read/write set. A running, transactional core whose set is hit aborts its own transaction, so the requester always wins. The aborting core receives a one-cycle abort pulse, which also starts the restore of its register checkpoint. The core then drops into a low-power sleep for a pseudo-random backoff followed by a fixed wake penalty. Finally it gets a one-cycle retry pulse to re-execute the transaction.

The backoff is drawn from a free-running 16-bit LFSR. It is masked by a per-core window that widens by one bit on each abort that follows without a commit in between, and the window narrows back to its minimum on commit. No new bus states or signals are needed. The block reuses the existing invalidate strobe, the index of the requesting core and the per-core set-hit response.

The block also arbitrates serial mode. When a transaction overflows its cache, the core raises an overflow request. One requester at a time, the lowest index first, becomes the serial owner. Every other core is stalled until the owner commits or aborts.

Top module: `eager_conflict_seq`

## Requirements
- R1: When `snoop_inv` is high in a cycle where core i is running (not asleep), has `tx_active[i]` and `set_hit[i]` high, and `snoop_src` is not i, then `abort_p[i]` is high for exactly the next cycle.
- R2: The core named by `snoop_src` never aborts because of its own invalidate, whatever its hit and active inputs are.
- R3: No abort happens for a core without `snoop_inv`, without `set_hit[i]` or without `tx_active[i]`, and such a core does not go to sleep.
- R4: `core_sleep[i]` rises in the same cycle as `abort_p[i]`. It stays high for B+1+WAKE_CYC cycles, where B is the backoff drawn at the abort, 0 <= B <= 2^W-1, and W is the window width (WAKE_CYC = 400 at 200 MHz, which is 2 us).
- R5: W starts at WIN_MIN (2) after reset. Each abort uses the current W and then raises it by one, up to WIN_MAX (8). A cycle with `tx_commit[i]` high sets W back to WIN_MIN.
- R6: `retry_p[i]` is high for exactly one cycle: the first cycle in which `core_sleep[i]` is low after being high. It is low at all other times.
- R7: An invalidate that hits a sleeping core causes no abort and does not extend its sleep.
- R8: With no serial owner, if any `ovf_req` bit is high, the lowest-index requester becomes owner. Its `serial_grant` bit is high from the next cycle, and `serial_grant` is one-hot or zero.
- R9: While an owner exists, `tx_stall` is high for every other core and low for the owner, and other overflow requests do not change the owner.
- R10: When `tx_commit` or `abort_p` of the owner is high, `serial_grant` and `tx_stall` are all zero in the next cycle. A pending request is granted one cycle after that.
- R11: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | NCORE | Core is executing inside a transaction |
| snoop_inv | input | 1 | Invalidate broadcast seen on the bus this cycle |
| snoop_src | input | $clog2(NCORE) | Index of the core issuing the invalidate |
| set_hit | input | NCORE | Snooped line is in that core's transactional set |
| tx_commit | input | NCORE | Core commits its transaction this cycle |
| ovf_req | input | NCORE | Core's transaction has overflowed and asks for serial mode |
| abort_p | output | NCORE | One-cycle abort and checkpoint-restore pulse |
| core_sleep | output | NCORE | Core held in low power (backoff and wake penalty) |
| retry_p | output | NCORE | One-cycle pulse: core may re-execute its transaction |
| serial_grant | output | NCORE | Core owns serial mode |
| tx_stall | output | NCORE | Core must not execute transactions (another core owns serial mode) |

## Verification
An invalidate sampled at one edge shows up as `abort_p` and a raised `core_sleep` in the following cycle. The abort is gone one cycle after that. `retry_p` coincides with the first low `core_sleep` cycle. Serial grants, stalls and releases each follow their cause by one registered cycle. The bench drives inputs on falling edges and samples on the falling edge after the edge that registers each result, so every check lands in exactly the cycle in which the result is due. Sleep length is counted sample by sample and compared with the window bounds derived from the number of aborts since the last commit.

// File: rtl/eager_conflict_seq.sv
`timescale 1ns/1ps
module eager_conflict_seq #(
  parameter int          NCORE    = 4,
  parameter int          WAKE_CYC = 400,
  parameter int          WIN_MIN  = 2,
  parameter int          WIN_MAX  = 8,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORE-1:0]         tx_active,
  input  logic                     snoop_inv,
  input  logic [$clog2(NCORE)-1:0] snoop_src,
  input  logic [NCORE-1:0]         set_hit,
  input  logic [NCORE-1:0]         tx_commit,
  input  logic [NCORE-1:0]         ovf_req,
  output logic [NCORE-1:0]         abort_p,
  output logic [NCORE-1:0]         core_sleep,
  output logic [NCORE-1:0]         retry_p,
  output logic [NCORE-1:0]         serial_grant,
  output logic [NCORE-1:0]         tx_stall
);
  localparam int SW = $clog2(NCORE);
  localparam int CW = ($clog2(WAKE_CYC) > WIN_MAX) ? $clog2(WAKE_CYC) : WIN_MAX;
  localparam int WW = $clog2(WIN_MAX + 1);

  typedef enum logic [1:0] {RUN, BACK, WAKE} ph_t;

  logic [15:0] lfsr;
  logic [31:0] lfsr2;
  assign lfsr2 = {lfsr, lfsr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);

  logic          own_vld;
  logic [SW-1:0] own_idx;
  logic [SW-1:0] pick;
  logic          own_done;

  always_comb begin
    pick = '0;
    for (int k = NCORE - 1; k >= 0; k--)
      if (ovf_req[k]) pick = SW'(k);
  end

  assign own_done = own_vld && (tx_commit[own_idx] || abort_p[own_idx]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (own_done) begin
      own_vld <= 1'b0;
    end else if (!own_vld && |ovf_req) begin
      own_vld <= 1'b1;
      own_idx <= pick;
    end

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    ph_t                ph;
    logic [CW-1:0]      cnt;
    logic [WW-1:0]      win;
    logic [WIN_MAX-1:0] mask;
    logic [15:0]        rnd;
    logic               hit, ab, rt;

    assign rnd  = lfsr2[4*(i%4) +: 16];
    assign mask = WIN_MAX'((32'd1 << win) - 32'd1);
    assign hit  = snoop_inv && set_hit[i] && tx_active[i] && (ph == RUN) && (snoop_src != SW'(i));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ph  <= RUN;
        cnt <= '0;
        win <= WW'(WIN_MIN);
        ab  <= 1'b0;
        rt  <= 1'b0;
      end else begin
        ab <= hit;
        rt <= 1'b0;
        if (tx_commit[i]) win <= WW'(WIN_MIN);
        case (ph)
          RUN: if (hit) begin
            ph  <= BACK;
            cnt <= CW'(rnd[WIN_MAX-1:0] & mask);
            if (win < WW'(WIN_MAX)) win <= win + 1'b1;
          end
          BACK: if (cnt == '0) begin
            ph  <= WAKE;
            cnt <= CW'(WAKE_CYC - 1);
          end else cnt <= cnt - 1'b1;
          WAKE: if (cnt == '0) begin
            ph <= RUN;
            rt <= 1'b1;
          end else cnt <= cnt - 1'b1;
          default: ph <= RUN;
        endcase
      end

    assign abort_p[i]      = ab;
    assign retry_p[i]      = rt;
    assign core_sleep[i]   = (ph != RUN);
    assign serial_grant[i] = own_vld && (own_idx == SW'(i));
    assign tx_stall[i]     = own_vld && (own_idx != SW'(i));
  end
endmodule

// File: rtl/eager_conflict_seq_chk.sv
`timescale 1ns/1ps
module eager_conflict_seq_chk #(
  parameter int NCORE = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCORE-1:0]         tx_active,
  input logic                     snoop_inv,
  input logic [$clog2(NCORE)-1:0] snoop_src,
  input logic [NCORE-1:0]         set_hit,
  input logic [NCORE-1:0]         tx_commit,
  input logic [NCORE-1:0]         abort_p,
  input logic [NCORE-1:0]         core_sleep,
  input logic [NCORE-1:0]         retry_p,
  input logic [NCORE-1:0]         serial_grant,
  input logic [NCORE-1:0]         tx_stall
);
  localparam int SW = $clog2(NCORE);

  for (genvar i = 0; i < NCORE; i++) begin : g_chk
    // R1
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p[i] |=> !abort_p[i]);
    // R3
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p[i] |-> $past(snoop_inv && set_hit[i] && tx_active[i]));
    // R2
    requester_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_inv && snoop_src == SW'(i)) |=> !abort_p[i]);
    // R4
    abort_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p[i] |-> (core_sleep[i] && $rose(core_sleep[i])));
    // R6
    retry_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_p[i] |-> (!core_sleep[i] && $past(core_sleep[i])));
    // R7
    sleep_deaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_sleep[i] |=> !abort_p[i]);
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(serial_grant));
  // R9
  stall_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|serial_grant) |-> (tx_stall == ~serial_grant));
  // R9
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|serial_grant) |-> (tx_stall == '0));
  // R10
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|serial_grant) && !(|(serial_grant & (tx_commit | abort_p)))) |=> $stable(serial_grant));
endmodule

bind eager_conflict_seq eager_conflict_seq_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .snoop_inv(snoop_inv),
  .snoop_src(snoop_src), .set_hit(set_hit), .tx_commit(tx_commit),
  .abort_p(abort_p), .core_sleep(core_sleep), .retry_p(retry_p),
  .serial_grant(serial_grant), .tx_stall(tx_stall)
);

// File: tb/tb_eager_conflict_seq.sv
`timescale 1ns/1ps
module tb_eager_conflict_seq;
  localparam int WAKE = 400;
  localparam int WMIN = 2;
  localparam int WMAX = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_active = '0, set_hit = '0, tx_commit = '0, ovf_req = '0;
  logic       snoop_inv = 1'b0;
  logic [1:0] snoop_src = '0;
  logic [3:0] abort_p, core_sleep, retry_p, serial_grant, tx_stall;

  int vecs = 0;
  int errs = 0;
  int wexp[4];

  always #2.5 clk = ~clk;

  eager_conflict_seq #(.NCORE(4), .WAKE_CYC(WAKE), .WIN_MIN(WMIN), .WIN_MAX(WMAX)) dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .snoop_inv(snoop_inv),
    .snoop_src(snoop_src), .set_hit(set_hit), .tx_commit(tx_commit), .ovf_req(ovf_req),
    .abort_p(abort_p), .core_sleep(core_sleep), .retry_p(retry_p),
    .serial_grant(serial_grant), .tx_stall(tx_stall)
  );

  task automatic chk(input string r, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic chk_rng(input string r, input int act, input int lo, input int hi);
    vecs++;
    if (act < lo || act > hi) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d..%0d at %0t", r, act, lo, hi, $time);
    end
  endtask

  task automatic commit_all();
    tx_commit = 4'hF;
    @(negedge clk);
    tx_commit = '0;
    for (int k = 0; k < 4; k++) wexp[k] = WMIN;
  endtask

  task automatic do_abort(input int src, input logic [3:0] hit, input logic [3:0] act,
                          input bit inv, input bit reinj, input string tag);
    logic [3:0] exp_ab, prev;
    int len[4];
    int n;
    exp_ab = inv ? (hit & act & ~(4'b0001 << src)) : 4'b0000;
    snoop_src = 2'(src); set_hit = hit; tx_active = act; snoop_inv = inv;
    prev = '0; n = 0;
    for (int k = 0; k < 4; k++) len[k] = 0;
    forever begin
      @(negedge clk); n++;
      if (n == 1) begin
        chk("R1 abort pattern", abort_p, exp_ab);
        chk("R4 sleep with abort", core_sleep, exp_ab);
        snoop_inv = 1'b0;
      end
      if (n == 2) chk("R1 single pulse", abort_p, 0);
      if (n == 3 && reinj) begin
        snoop_inv = 1'b1; set_hit = 4'hF; tx_active = exp_ab;
      end
      if (n == 4 && reinj) begin
        chk("R7 sleeping core ignores invalidate", abort_p, 0);
        snoop_inv = 1'b0;
      end
      for (int k = 0; k < 4; k++) begin
        if (core_sleep[k]) len[k]++;
        chk("R6 retry pulse", retry_p[k], prev[k] & ~core_sleep[k]);
      end
      prev = core_sleep;
      if ((n >= 5 && core_sleep == '0) || n > 3000) break;
    end
    for (int k = 0; k < 4; k++) begin
      if (exp_ab[k]) begin
        chk_rng(tag, len[k], WAKE + 1, WAKE + (1 << wexp[k]));
        if (wexp[k] < WMAX) wexp[k]++;
      end else begin
        chk("R3 no sleep without conflict", len[k], 0);
      end
    end
    tx_active = '0; set_hit = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) wexp[k] = WMIN;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 abort in reset", abort_p, 0);
    chk("R11 sleep in reset", core_sleep, 0);
    chk("R11 grant in reset", serial_grant, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 abort after reset", abort_p, 0);
    chk("R11 sleep after reset", core_sleep, 0);
    chk("R11 retry after reset", retry_p, 0);
    chk("R11 grant after reset", serial_grant, 0);
    chk("R11 stall after reset", tx_stall, 0);

    // R1 R2 R3 R4 R6: sweep requester, hit pattern, active pattern, strobe
    for (int s = 0; s < 4; s++)
      for (int h = 0; h < 16; h++)
        for (int a = 0; a < 3; a++)
          for (int v = 0; v < 2; v++) begin
            do_abort(s, 4'(h), (a == 0) ? 4'hF : ((a == 1) ? 4'hA : 4'h5), v[0], 1'b0, "R4 sleep length");
            commit_all();
          end

    // R5: window widens on consecutive aborts, commit narrows it
    for (int r = 0; r < 9; r++) do_abort(0, 4'b0010, 4'b0010, 1'b1, 1'b0, "R5 widening window");
    chk("R5 window saturated", wexp[1], WMAX);
    commit_all();
    do_abort(0, 4'b0010, 4'b0010, 1'b1, 1'b0, "R5 window after commit");

    // R7: invalidate during sleep
    do_abort(3, 4'b0110, 4'b0110, 1'b1, 1'b1, "R7 sleep not extended");
    commit_all();

    // R8 R9 R10: every request pattern
    for (int q = 1; q < 16; q++) begin
      int low;
      low = 0;
      for (int k = 3; k >= 0; k--) if (q[k]) low = k;
      ovf_req = 4'(q);
      @(negedge clk);
      chk("R8 lowest index granted", serial_grant, 1 << low);
      chk("R9 others stalled", tx_stall, 4'hF & ~(1 << low));
      ovf_req = 4'hF;
      @(negedge clk);
      chk("R9 owner kept", serial_grant, 1 << low);
      ovf_req = '0;
      tx_commit = 4'(1 << low);
      @(negedge clk);
      tx_commit = '0;
      chk("R10 release on commit", serial_grant, 0);
      chk("R10 stall cleared", tx_stall, 0);
    end

    // R10: back-to-back hand-over
    ovf_req = 4'b0110;
    @(negedge clk);
    chk("R8 pair grant", serial_grant, 4'b0010);
    ovf_req = 4'b0100;
    tx_commit = 4'b0010;
    @(negedge clk);
    tx_commit = '0;
    chk("R10 gap cycle", serial_grant, 0);
    @(negedge clk);
    chk("R10 next owner", serial_grant, 4'b0100);
    ovf_req = '0;
    tx_commit = 4'b0100;
    @(negedge clk);
    tx_commit = '0;

    // R10: owner released by its own abort
    ovf_req = 4'b0010;
    @(negedge clk);
    ovf_req = '0;
    chk("R8 owner one", serial_grant, 4'b0010);
    snoop_src = 2'd0; set_hit = 4'b0010; tx_active = 4'b0010; snoop_inv = 1'b1;
    @(negedge clk);
    snoop_inv = 1'b0;
    chk("R1 owner aborted", abort_p, 4'b0010);
    chk("R9 grant held during abort", serial_grant, 4'b0010);
    @(negedge clk);
    chk("R10 release on abort", serial_grant, 0);
    tx_active = '0; set_hit = '0;
    for (int c = 0; c < 2000 && core_sleep != '0; c++) @(negedge clk);
    chk("R4 sleep ended", core_sleep, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule